// File: doc/BRIEF.md
# Fully Associative FIFO Cache Profiler

This block models the lookup and bookkeeping of a fully associative cache with write-back and write-allocate behaviour. It keeps no data, only a tag, a valid bit and a dirty bit per line. A stream of read and write requests is fed in, one per cycle at most. The block reports for each request, one cycle later, whether it hit. It also keeps six statistics counters: words fetched from external memory, words written back to it, and hits and misses for reads and for writes.

The total capacity is fixed at 256 words. A run-time mode trades block size against the number of lines, from 256 lines of one word up to 2 lines of 128 words. Victims are chosen first-in-first-out with a single pointer that walks the active lines. A synchronous clear input starts a new run. Any change of the mode input also starts a new run, so that statistics from different geometries never mix. The block is meant for evaluating cache geometries against address traces in hardware.

Top module: `fa_cache_stats`

## Requirements
- R1: `mode_i` value k (0 to 7) selects a block of 2^k words and 256 >> k active lines. The tag of a request is `req_addr_i >> k`, so addresses that differ only in their low k bits fall in the same block.
- R2: A request is accepted in a cycle where `req_valid_i` is 1 and no clear takes place. In the following cycle `resp_valid_o` is 1, and `resp_hit_o` is 1 exactly when a valid active line holds the request's tag. The counters show the effect of that request in the same cycle as its response.
- R3: Lines are allocated by a pointer that starts at line 0 after a clear. The pointer advances by one on each miss and wraps to 0 after the last active line.
- R4: On a read miss, `ext_rd_o` grows by the block size and `rd_miss_o` by one. If the victim line is dirty, `ext_wr_o` also grows by the block size. The new line is valid and clean.
- R5: A read hit increments only `rd_hit_o`. A write hit increments only `wr_hit_o` and marks the matching line dirty. A hit never changes `ext_rd_o` or `ext_wr_o`.
- R6: On a write miss, `ext_rd_o` grows by the block size and `wr_miss_o` by one. If the victim line is dirty, `ext_wr_o` also grows by the block size. The new line is valid and dirty.
- R7: When `clear_i` is 1, or `mode_i` differs from its value in the previous cycle, every tag, valid bit, dirty bit, the pointer and all six counters return to zero. A request in that cycle is dropped and gets no response.
- R8: While `req_valid_i` is 0, the other request inputs have no effect: no response appears and no counter changes.
- R9: Each counter is `CNT_W` bits wide (default 32). A counter holds at 2^CNT_W - 1 instead of wrapping.
- R10: While `rst_n` is 0 at a clock edge, the block returns to the cleared state: mode register 0, all counters 0, no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear_i | input | 1 | Start a new run (clears state and counters) |
| mode_i | input | 3 | Geometry select k: block 2^k words, 256 >> k lines |
| req_valid_i | input | 1 | A request is present |
| req_write_i | input | 1 | 1 = write request, 0 = read request |
| req_addr_i | input | 16 | Word address of the request |
| resp_valid_o | output | 1 | Response for the request accepted in the previous cycle |
| resp_hit_o | output | 1 | That request hit |
| ext_rd_o | output | 32 | Words fetched from external memory |
| ext_wr_o | output | 32 | Words written back to external memory |
| rd_hit_o | output | 32 | Read hits |
| rd_miss_o | output | 32 | Read misses |
| wr_hit_o | output | 32 | Write hits |
| wr_miss_o | output | 32 | Write misses |

## Verification
The bound checker watches properties that hold on every cycle. Every accepted request is answered in the next cycle, and idle cycles or clear cycles produce no response. A clear leaves all counters at zero. A hit never moves the traffic counters, a miss always moves the fetch counter unless it is saturated, and no counter falls between clears. Which line is the victim, whether it was dirty, and how tags are formed per mode depend on the history of the request stream. Only the bench can show these. It compares every response and every counter value against a reference model that it keeps itself. The stimulus is a random stream in all eight modes plus directed sequences for FIFO wrap, dirty eviction, mode changes, clears, idle inputs and saturation of a narrow-counter instance.

// File: rtl/fcs_pkg.sv
// Package: shared event type and request classification for the cache profiler.
// Assumes one request per cycle at most; the event drives all counter updates.
package fcs_pkg;

    // One accepted request produces exactly one of the four outcome flags,
    // plus optional block fetch and write-back flags.
    typedef struct packed {
        logic rd_hit;
        logic rd_miss;
        logic wr_hit;
        logic wr_miss;
        logic fetch;
        logic evict;
    } fcs_event_t;

    // Turn an accepted request and its lookup result into counter events.
    function automatic fcs_event_t classify(
        input logic acc,
        input logic wr,
        input logic hit,
        input logic victim_dirty
    );
        fcs_event_t ev;
        ev = '0;
        if (acc) begin
            ev.rd_hit  = !wr && hit;
            ev.wr_hit  = wr && hit;
            ev.rd_miss = !wr && !hit;
            ev.wr_miss = wr && !hit;
            ev.fetch   = !hit;
            ev.evict   = !hit && victim_dirty;
        end
        return ev;
    endfunction

endpackage

// File: rtl/fcs_tag_store.sv
// Module: tag, valid and dirty storage with a fully parallel lookup.
// Every line compares its tag in the same cycle; lines at or above
// active_cnt never match. Allocation writes one line selected by alloc_idx.
// Assumes alloc_en and mark_dirty are never both set in one cycle.
module fcs_tag_store #(
    parameter int unsigned LINES = 256,
    parameter int unsigned TAG_W = 16,
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [IDX_W:0]   active_cnt,
    input  logic [TAG_W-1:0] look_tag,
    input  logic             mark_dirty,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             alloc_dirty,
    output logic             hit_o,
    output logic             victim_dirty_o
);

    logic [LINES-1:0] match_vec;
    logic [LINES-1:0] dirty_vec;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam logic [IDX_W:0] LID = (IDX_W+1)'(g);
        logic [TAG_W-1:0] tag_r;
        logic             vld_r;
        logic             drt_r;
        logic             sel;

        assign sel          = alloc_en && (alloc_idx == LID[IDX_W-1:0]);
        assign match_vec[g] = vld_r && (tag_r == look_tag) && (LID < active_cnt);
        assign dirty_vec[g] = drt_r;

        // Line state: cleared, refilled on allocation, or marked dirty on a write hit.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                tag_r <= '0;
                vld_r <= 1'b0;
                drt_r <= 1'b0;
            end else if (sel) begin
                tag_r <= look_tag;
                vld_r <= 1'b1;
                drt_r <= alloc_dirty;
            end else if (mark_dirty && match_vec[g]) begin
                drt_r <= 1'b1;
            end
        end
    end

    assign hit_o          = |match_vec;
    assign victim_dirty_o = dirty_vec[alloc_idx];

endmodule

// File: rtl/fcs_fifo_ptr.sv
// Module: first-in-first-out victim pointer.
// Advances by one per allocation and wraps to zero at the active line count.
// Assumes limit is at least 1 and changes only together with a clear.
module fcs_fifo_ptr #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [IDX_W:0]   limit,
    output logic [IDX_W-1:0] ptr_o
);

    logic [IDX_W:0] nxt;

    assign nxt = (IDX_W+1)'(ptr_o) + (IDX_W+1)'(1);

    // Pointer register: reset, clear, or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr_o <= '0;
        end else if (adv) begin
            ptr_o <= (nxt >= limit) ? '0 : nxt[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/fcs_sat_counter.sv
// Module: saturating accumulator for one statistic.
// Adds inc_amt when inc_en is set and holds at all-ones instead of wrapping.
// Assumes inc_amt fits in INC_W bits; the sum is formed one bit wider than both.
module fcs_sat_counter #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc_amt,
    output logic [CNT_W-1:0] count_o
);

    localparam int unsigned SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
    localparam logic [SUM_W-1:0] CEIL = SUM_W'({CNT_W{1'b1}});

    logic [SUM_W-1:0] sum;

    assign sum = SUM_W'(count_o) + SUM_W'(inc_amt);

    // Count register: clear, or add with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count_o <= '0;
        end else if (inc_en) begin
            count_o <= (sum > CEIL) ? '1 : sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/fa_cache_stats.sv
// Module: fully associative FIFO cache profiler (top).
// Classifies each request as hit or miss against a tag-only cache whose
// geometry is picked at run time. It keeps six statistics counters and
// answers one cycle after each accepted request.
// Assumes: the capacity is 2^CAP_LOG2 words and modes 0..CAP_LOG2-1 are used.
// A mode change or clear_i empties the cache and drops that cycle's request.
module fa_cache_stats #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned CAP_LOG2 = 8,
    parameter int unsigned CNT_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic [$clog2(CAP_LOG2)-1:0]  mode_i,
    input  logic                         req_valid_i,
    input  logic                         req_write_i,
    input  logic [ADDR_W-1:0]            req_addr_i,
    output logic                         resp_valid_o,
    output logic                         resp_hit_o,
    output logic [CNT_W-1:0]             ext_rd_o,
    output logic [CNT_W-1:0]             ext_wr_o,
    output logic [CNT_W-1:0]             rd_hit_o,
    output logic [CNT_W-1:0]             rd_miss_o,
    output logic [CNT_W-1:0]             wr_hit_o,
    output logic [CNT_W-1:0]             wr_miss_o
);

    import fcs_pkg::*;

    localparam int unsigned MODE_W = $clog2(CAP_LOG2);
    localparam int unsigned LINES  = 1 << CAP_LOG2;
    localparam int unsigned IDX_W  = CAP_LOG2;
    localparam int unsigned INC_W  = CAP_LOG2;
    localparam int unsigned N_CNT  = 6;

    logic [MODE_W-1:0] mode_q;
    logic              run_clr;
    logic              accept;
    logic [ADDR_W-1:0] look_tag;
    logic [IDX_W:0]    active_cnt;
    logic [INC_W-1:0]  blk_words;
    logic              hit;
    logic              victim_dirty;
    logic [IDX_W-1:0]  victim_idx;
    fcs_event_t        ev;

    logic [N_CNT-1:0]  cnt_inc;
    logic [INC_W-1:0]  cnt_amt [N_CNT];
    logic [CNT_W-1:0]  cnt_val [N_CNT];

    // Mode register: remembers the geometry of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_i;
        end
    end

    assign run_clr    = clear_i || (mode_i != mode_q);
    assign accept     = req_valid_i && !run_clr;
    assign look_tag   = req_addr_i >> mode_q;
    assign active_cnt = (IDX_W+1)'(LINES) >> mode_q;
    assign blk_words  = INC_W'(1) << mode_q;

    fcs_tag_store #(
        .LINES (LINES),
        .TAG_W (ADDR_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr            (run_clr),
        .active_cnt     (active_cnt),
        .look_tag       (look_tag),
        .mark_dirty     (ev.wr_hit),
        .alloc_en       (ev.fetch),
        .alloc_idx      (victim_idx),
        .alloc_dirty    (req_write_i),
        .hit_o          (hit),
        .victim_dirty_o (victim_dirty)
    );

    fcs_fifo_ptr #(
        .IDX_W (IDX_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (run_clr),
        .adv   (ev.fetch),
        .limit (active_cnt),
        .ptr_o (victim_idx)
    );

    assign ev = classify(accept, req_write_i, hit, victim_dirty);

    // Counter order: external fetch, write-back, read hit, read miss, write hit, write miss.
    assign cnt_inc = {ev.wr_miss, ev.wr_hit, ev.rd_miss, ev.rd_hit, ev.evict, ev.fetch};

    // Increment amount per counter: traffic counters move a block, the others one.
    always_comb begin
        for (int k = 0; k < N_CNT; k++) begin
            cnt_amt[k] = (k < 2) ? blk_words : INC_W'(1);
        end
    end

    for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
        fcs_sat_counter #(
            .CNT_W (CNT_W),
            .INC_W (INC_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (run_clr),
            .inc_en  (cnt_inc[c]),
            .inc_amt (cnt_amt[c]),
            .count_o (cnt_val[c])
        );
    end

    assign ext_rd_o  = cnt_val[0];
    assign ext_wr_o  = cnt_val[1];
    assign rd_hit_o  = cnt_val[2];
    assign rd_miss_o = cnt_val[3];
    assign wr_hit_o  = cnt_val[4];
    assign wr_miss_o = cnt_val[5];

    // Response register: one-cycle answer for each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_o <= 1'b0;
            resp_hit_o   <= 1'b0;
        end else begin
            resp_valid_o <= accept;
            resp_hit_o   <= accept && hit;
        end
    end

endmodule

// File: rtl/fcs_checker.sv
// Module: property checker for the cache profiler, attached by bind.
// Observes the ports and the internal run-clear strobe; drives nothing.
module fcs_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_clr,
    input logic             req_valid_i,
    input logic             resp_valid_o,
    input logic             resp_hit_o,
    input logic [CNT_W-1:0] ext_rd_o,
    input logic [CNT_W-1:0] ext_wr_o,
    input logic [CNT_W-1:0] rd_hit_o,
    input logic [CNT_W-1:0] rd_miss_o,
    input logic [CNT_W-1:0] wr_hit_o,
    input logic [CNT_W-1:0] wr_miss_o
);

    a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !run_clr) |=> resp_valid_o);

    a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit_o |-> resp_valid_o);

    a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !resp_valid_o);

    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        run_clr |=> !resp_valid_o);

    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        run_clr |=> (ext_rd_o == '0 && ext_wr_o == '0 && rd_hit_o == '0 &&
                     rd_miss_o == '0 && wr_hit_o == '0 && wr_miss_o == '0));

    a_r5_hit_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && resp_hit_o) |-> ($stable(ext_rd_o) && $stable(ext_wr_o)));

    a_r4_miss_fetches: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && !resp_hit_o) |-> ((ext_rd_o != $past(ext_rd_o)) || (&ext_rd_o)));

    a_r9_no_fall_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !run_clr |=> (ext_rd_o >= $past(ext_rd_o) && rd_hit_o >= $past(rd_hit_o) &&
                      rd_miss_o >= $past(rd_miss_o)));

    a_r9_no_fall_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !run_clr |=> (ext_wr_o >= $past(ext_wr_o) && wr_hit_o >= $past(wr_hit_o) &&
                      wr_miss_o >= $past(wr_miss_o)));

endmodule

bind fa_cache_stats fcs_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_clr      (run_clr),
    .req_valid_i  (req_valid_i),
    .resp_valid_o (resp_valid_o),
    .resp_hit_o   (resp_hit_o),
    .ext_rd_o     (ext_rd_o),
    .ext_wr_o     (ext_wr_o),
    .rd_hit_o     (rd_hit_o),
    .rd_miss_o    (rd_miss_o),
    .wr_hit_o     (wr_hit_o),
    .wr_miss_o    (wr_miss_o)
);

// File: tb/test_fa_cache_stats.sv
// Scoreboard bench: the driver updates a reference cache model and queues the
// expected response; the monitor pops and compares at each response.
module test_fa_cache_stats;

    localparam int unsigned NW = 6;   // narrow counter width for the R9 instance
    localparam longint NMAX = 63;

    typedef struct packed {
        logic             hit;
        logic [5:0][63:0] cnt;
        logic [3:0]       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [15:0] req_addr_i = 16'd0;

    logic          resp_valid_o, resp_hit_o;
    logic [31:0]   wc [6];
    logic          n_resp_valid, n_resp_hit;
    logic [NW-1:0] nc [6];

    int   n_chk = 0;
    int   n_err = 0;
    exp_t sb_q [$];
    exp_t mon_e;

    // Reference model state
    int unsigned m_tag [256];
    bit          m_vld [256];
    bit          m_drt [256];
    int          m_ptr = 0;
    int          m_mode = 0;
    longint      m_cnt [6];

    always #5 clk = ~clk;

    fa_cache_stats i_fa_cache_stats (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .mode_i(mode_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o),
        .ext_rd_o(wc[0]), .ext_wr_o(wc[1]), .rd_hit_o(wc[2]),
        .rd_miss_o(wc[3]), .wr_hit_o(wc[4]), .wr_miss_o(wc[5])
    );

    fa_cache_stats #(.CNT_W(NW)) i_fa_cache_stats_sat (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .mode_i(mode_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .resp_valid_o(n_resp_valid), .resp_hit_o(n_resp_hit),
        .ext_rd_o(nc[0]), .ext_wr_o(nc[1]), .rd_hit_o(nc[2]),
        .rd_miss_o(nc[3]), .wr_hit_o(nc[4]), .wr_miss_o(nc[5])
    );

    function automatic string rname(input logic [3:0] code);
        case (code)
            4'd1: return "R1";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R2";
        endcase
    endfunction

    function automatic longint sat6(input longint v);
        return (v > NMAX) ? NMAX : v;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic model_clear(input int k);
        for (int i = 0; i < 256; i++) begin
            m_tag[i] = 0; m_vld[i] = 0; m_drt[i] = 0;
        end
        for (int i = 0; i < 6; i++) m_cnt[i] = 0;
        m_ptr  = 0;
        m_mode = k;
    endtask

    // Reference policy: parallel tag search, FIFO victim, write-back, write-allocate.
    task automatic model_push(input bit wr, input logic [15:0] addr, input int code);
        int          lines;
        int          blk;
        int unsigned t;
        int          hidx;
        exp_t        e;
        lines = 256 >> m_mode;
        blk   = 1 << m_mode;
        t     = 32'(addr) >> m_mode;
        hidx  = -1;
        for (int i = 0; i < lines; i++)
            if (m_vld[i] && m_tag[i] == t) hidx = i;
        if (hidx >= 0) begin
            if (wr) begin m_cnt[4]++; m_drt[hidx] = 1; end
            else m_cnt[2]++;
        end else begin
            m_cnt[0] += blk;
            if (m_drt[m_ptr]) m_cnt[1] += blk;
            if (wr) m_cnt[5]++; else m_cnt[3]++;
            m_tag[m_ptr] = t; m_vld[m_ptr] = 1; m_drt[m_ptr] = wr;
            m_ptr = (m_ptr + 1) % lines;
        end
        e.hit = (hidx >= 0);
        for (int i = 0; i < 6; i++) e.cnt[i] = 64'(m_cnt[i]);
        e.req = 4'(code);
        sb_q.push_back(e);
    endtask

    task automatic do_req(input bit wr, input int addr, input int code);
        @(negedge clk);
        clear_i = 1'b0; req_valid_i = 1'b1; req_write_i = wr; req_addr_i = 16'(addr);
        model_push(wr, 16'(addr), code);
    endtask

    task automatic drop();
        @(negedge clk);
        req_valid_i = 1'b0; clear_i = 1'b0;
    endtask

    // Mode change with a request in the same cycle: request must be dropped (R7).
    task automatic set_mode(input int k);
        @(negedge clk);
        clear_i = 1'b0; mode_i = 3'(k);
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 16'h0005;
        if (k != m_mode) model_clear(k);
        else model_push(1'b1, 16'h0005, 7);
    endtask

    task automatic do_clear(input int addr);
        @(negedge clk);
        clear_i = 1'b1; req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 16'(addr);
        model_clear(m_mode);
    endtask

    task automatic chk_all_zero(input string rq);
        for (int i = 0; i < 6; i++) begin
            chk(wc[i] == 32'd0, rq, $sformatf("counter %0d zero", i), longint'(wc[i]), 0);
            chk(nc[i] == '0, rq, $sformatf("narrow counter %0d zero", i), longint'(nc[i]), 0);
        end
        chk(resp_valid_o == 1'b0, rq, "no response", longint'(resp_valid_o), 0);
    endtask

    // Monitor: compares each response and its counter snapshot with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (resp_valid_o || n_resp_valid)) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2", "response without accepted request", 1, 0);
            end else begin
                mon_e = sb_q.pop_front();
                chk(n_resp_valid == resp_valid_o, rname(mon_e.req), "narrow response valid",
                    longint'(n_resp_valid), longint'(resp_valid_o));
                chk(resp_hit_o == mon_e.hit, rname(mon_e.req), "hit flag",
                    longint'(resp_hit_o), longint'(mon_e.hit));
                chk(n_resp_hit == mon_e.hit, rname(mon_e.req), "narrow hit flag",
                    longint'(n_resp_hit), longint'(mon_e.hit));
                for (int i = 0; i < 6; i++) begin
                    chk(longint'(wc[i]) == longint'(mon_e.cnt[i]), rname(mon_e.req),
                        $sformatf("counter %0d", i), longint'(wc[i]), longint'(mon_e.cnt[i]));
                    chk(longint'(nc[i]) == sat6(longint'(mon_e.cnt[i])), "R9",
                        $sformatf("narrow counter %0d", i), longint'(nc[i]),
                        sat6(longint'(mon_e.cnt[i])));
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        model_clear(0);
        // R10: reset state
        repeat (3) @(negedge clk);
        chk_all_zero("R10");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all_zero("R10");

        // R4, R5, R6: basic outcomes in mode 0 (block 1, 256 lines)
        do_req(1'b0, 16'h10, 4);   // read miss
        do_req(1'b0, 16'h10, 5);   // read hit
        do_req(1'b1, 16'h10, 5);   // write hit, line dirty
        do_req(1'b1, 16'h11, 6);   // write miss
        drop();
        chk(wc[0] == 32'd2, "R4", "fetched words", longint'(wc[0]), 2);
        chk(wc[1] == 32'd0, "R5", "write-backs after hits", longint'(wc[1]), 0);
        chk(wc[2] == 32'd1 && wc[4] == 32'd1, "R5", "read+write hits",
            longint'(wc[2] + wc[4]), 2);
        chk(wc[5] == 32'd1, "R6", "write misses", longint'(wc[5]), 1);

        // R1: mode 3, block of 8 words; 0x20 and 0x27 share a tag, 0x28 does not
        set_mode(3);
        do_req(1'b0, 16'h20, 1);
        do_req(1'b0, 16'h27, 1);
        do_req(1'b0, 16'h28, 1);
        drop();
        chk(wc[0] == 32'd16, "R1", "fetched words with 8-word blocks", longint'(wc[0]), 16);
        chk(wc[2] == 32'd1, "R1", "hit within block", longint'(wc[2]), 1);

        // R3, R6, R9: mode 7, two lines of 128 words, FIFO wrap and dirty eviction
        set_mode(7);
        do_req(1'b1, 16'h000, 6);  // write miss -> line 0 dirty
        do_req(1'b0, 16'h080, 3);  // read miss -> line 1
        do_req(1'b0, 16'h100, 3);  // evicts dirty line 0
        do_req(1'b0, 16'h000, 3);  // pointer wrapped: evicts clean line 1
        do_req(1'b0, 16'h100, 3);  // still present: hit
        drop();
        chk(wc[1] == 32'd128, "R3", "one dirty eviction", longint'(wc[1]), 128);
        chk(wc[0] == 32'd512, "R3", "four block fetches", longint'(wc[0]), 512);
        chk(wc[2] == 32'd1, "R3", "hit after wrap", longint'(wc[2]), 1);
        chk(nc[0] == 6'd63, "R9", "narrow fetch counter holds", longint'(nc[0]), 63);
        chk(nc[3] == 6'd3, "R9", "narrow read misses", longint'(nc[3]), 3);

        // R8: inputs toggle while valid is low
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            req_valid_i = 1'b0; req_write_i = i[0]; req_addr_i = 16'(i * 97);
        end
        @(negedge clk);
        chk(resp_valid_o == 1'b0, "R8", "no response while idle", longint'(resp_valid_o), 0);
        for (int i = 0; i < 6; i++)
            chk(longint'(wc[i]) == m_cnt[i], "R8", $sformatf("counter %0d unchanged", i),
                longint'(wc[i]), m_cnt[i]);

        // R7: clear with a request in the same cycle
        do_clear(16'h100);
        drop();
        chk_all_zero("R7");
        do_req(1'b0, 16'h100, 7); // contents were cleared: must miss
        drop();
        chk(wc[3] == 32'd1 && wc[2] == 32'd0, "R7", "miss after clear",
            longint'(wc[3]), 1);

        // R2 and all policies: random stream in every mode
        for (int m = 0; m < 8; m++) begin
            set_mode((m + 1) % 8);
            drop();
            chk_all_zero("R7");
            for (int n = 0; n < 700; n++) begin
                if ($urandom_range(0, 3) == 0) drop();
                else do_req(1'($urandom_range(0, 1)), int'($urandom_range(0, 399)), 2);
            end
            drop();
            drop();
            chk(sb_q.size() == 0, "R2", "all responses seen", longint'(sb_q.size()), 0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule